// File: doc/BRIEF.md
# Bidirectional Cross-Pattern Motion Refinement

This block refines the motion of one 8×8 binary (one bit per pixel) block. A search run is given five starting vectors. Around each one it scores four positions: the vector itself, one row up, one row down and one column right. The left neighbour is never tried, so that one candidate fits the four sum-of-difference (SOD) engines of a lane in a single cycle. The SOD is the number of bit positions where the current block and the reference block differ. Each lane keeps the lowest SOD it has seen and the vector that produced it. The candidates are visited in a fixed order with no data-dependent branching.

In bidirectional mode two lanes run at once: one on the forward window and one on the backward window. Each lane visits all five candidates, one per cycle, and both best vectors are presented together. In unidirectional mode both lanes work on the forward window. One lane takes candidates 0 to 2 and the other takes candidates 3 and 4, so the search ends in three evaluation cycles. The two lane minima are then merged.

Control is a plain start/done pair. The block has no streaming interface, so there is no back-pressure: results are registered and stay unchanged from one done pulse to the next. The windows and the current block are plain parallel inputs that the surrounding logic holds steady for the length of a run.

Top module: `cross_refine`

## Requirements
- R1: After reset, done is low, all four output vector coordinates are 0 and both SOD outputs are 127 (all ones).
- R2: For each candidate (x,y) the block scores positions (x,y), (x,y-1), (x,y+1) and (x+1,y), in that order. It never scores (x-1,y). The SOD of a position is the number of differing bits between cur_blk and the 8×8 window region at that position.
- R3: A running minimum changes only when a new SOD is strictly smaller than the stored one. Ties keep the earlier position. Candidates are taken in index order 0..4, and within a candidate the points are taken in the order given in R2.
- R4: When bidir=1 is captured at start, the fwd outputs hold the best result over all five candidates on win_fwd. The bwd outputs hold the best result over all five candidates on win_bwd. Both are updated in the cycle where done is high.
- R5: When bidir=0 is captured at start, the fwd outputs hold the best result over all five candidates on win_fwd, with ties resolved toward the lower candidate index. The bwd outputs show vector (0,0) and SOD 127.
- R6: done goes high 8 rising clock edges after the edge that accepts start in bidirectional mode, and 6 edges after it in unidirectional mode.
- R7: Each coordinate of every scored position is clamped to the range -4..+4 (the search range) before it is scored. This includes candidates that are out of range and cross points that step past the edge.
- R8: A start that arrives while a run is in progress is ignored, along with the bidir value that comes with it. done is high for exactly one cycle, and the outputs hold their values until the next done.
- R9: Window bit row*16+col holds the pixel at that row and column. Vector (x,y) places the block's top-left pixel at column 4+x and row 4+y. cur_blk bit r*8+c holds block row r, column c. Candidate i is stored as a signed 4-bit field at bits [4i+3:4i] of cand_x and cand_y. Positive y points down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run when the block is idle |
| bidir | input | 1 | Mode sampled at start: 1 bidirectional, 0 unidirectional |
| cur_blk | input | 64 | Current 8×8 binary block |
| win_fwd | input | 256 | Forward 16×16 reference window |
| win_bwd | input | 256 | Backward 16×16 reference window |
| cand_x | input | 20 | Five signed horizontal candidate components |
| cand_y | input | 20 | Five signed vertical candidate components |
| done | output | 1 | One-cycle pulse when the results are updated |
| fwd_mv_x | output | 4 | Best forward horizontal component |
| fwd_mv_y | output | 4 | Best forward vertical component |
| fwd_sod | output | 7 | Best forward SOD |
| bwd_mv_x | output | 4 | Best backward horizontal component |
| bwd_mv_y | output | 4 | Best backward vertical component |
| bwd_sod | output | 7 | Best backward SOD |

## Verification
The assertions assume that cur_blk and both windows stay constant from the accepting edge until done. They also assume that the candidate fields carry any signed 4-bit value, so out-of-range vectors reach the clamp. The stimulus sets windows, block, candidates and mode before it pulses start, and it changes none of them until the scoreboard has taken the result. The one exception is start and bidir, which it toggles during a run to exercise the busy case. Clamping covers the extreme field values -8 and +7, so no position outside the window is ever indexed.

// File: rtl/cr_pkg.sv
package cr_pkg;

  typedef enum logic [2:0] {
    CR_IDLE,
    CR_INIT,
    CR_EVAL,
    CR_DRAIN,
    CR_FIN
  } cr_state_e;

  // Limit a coordinate to the symmetric search range.
  function automatic int cr_clamp(input int v, input int lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  // Cross point offsets, scan order: centre, up, down, right.
  function automatic int cr_pt_dx(input int k);
    return (k == 3) ? 1 : 0;
  endfunction

  function automatic int cr_pt_dy(input int k);
    if (k == 1) return -1;
    if (k == 2) return 1;
    return 0;
  endfunction

endpackage

// File: rtl/cr_sod_unit.sv
module cr_sod_unit #(
  parameter int BLK   = 8,
  parameter int RANGE = 4,
  parameter int MV_W  = 4,
  parameter int SOD_W = 7,
  parameter int WIN   = BLK + 2 * RANGE
) (
  input  logic [BLK*BLK-1:0]     cur,
  input  logic [WIN*WIN-1:0]     win,
  input  logic signed [MV_W-1:0] pos_x,
  input  logic signed [MV_W-1:0] pos_y,
  output logic [SOD_W-1:0]       sod
);

  logic [BLK*BLK-1:0] ref_blk;
  int col0;
  int row0;

  // Cut the 8x8 region out of the window at the (already clamped) position.
  always_comb begin
    col0 = int'(pos_x) + RANGE;
    row0 = int'(pos_y) + RANGE;
    ref_blk = '0;
    for (int r = 0; r < BLK; r++) begin
      for (int c = 0; c < BLK; c++) begin
        ref_blk[r*BLK+c] = win[(row0+r)*WIN + col0 + c];
      end
    end
  end

  assign sod = SOD_W'($countones(ref_blk ^ cur));

endmodule

// File: rtl/cr_cross_engine.sv
module cr_cross_engine import cr_pkg::*; #(
  parameter int BLK   = 8,
  parameter int RANGE = 4,
  parameter int MV_W  = 4,
  parameter int SOD_W = 7,
  parameter int WIN   = BLK + 2 * RANGE,
  parameter int NPT   = 4
) (
  input  logic [BLK*BLK-1:0]     cur,
  input  logic [WIN*WIN-1:0]     win,
  input  logic signed [MV_W-1:0] cen_x,
  input  logic signed [MV_W-1:0] cen_y,
  output logic signed [MV_W-1:0] best_x,
  output logic signed [MV_W-1:0] best_y,
  output logic [SOD_W-1:0]       best_sod
);

  logic signed [MV_W-1:0] pt_x   [NPT];
  logic signed [MV_W-1:0] pt_y   [NPT];
  logic [SOD_W-1:0]       pt_sod [NPT];

  for (genvar k = 0; k < NPT; k++) begin : g_pt
    localparam int DX = cr_pt_dx(k);
    localparam int DY = cr_pt_dy(k);

    assign pt_x[k] = MV_W'(cr_clamp(int'(cen_x) + DX, RANGE));
    assign pt_y[k] = MV_W'(cr_clamp(int'(cen_y) + DY, RANGE));

    cr_sod_unit #(
      .BLK(BLK), .RANGE(RANGE), .MV_W(MV_W), .SOD_W(SOD_W), .WIN(WIN)
    ) u_sod (
      .cur  (cur),
      .win  (win),
      .pos_x(pt_x[k]),
      .pos_y(pt_y[k]),
      .sod  (pt_sod[k])
    );
  end

  // Earlier point wins a tie: only a strictly smaller score replaces it.
  always_comb begin
    best_sod = pt_sod[0];
    best_x   = pt_x[0];
    best_y   = pt_y[0];
    for (int k = 1; k < NPT; k++) begin
      if (pt_sod[k] < best_sod) begin
        best_sod = pt_sod[k];
        best_x   = pt_x[k];
        best_y   = pt_y[k];
      end
    end
  end

endmodule

// File: rtl/cr_min_tracker.sv
module cr_min_tracker #(
  parameter int MV_W  = 4,
  parameter int SOD_W = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   upd,
  input  logic [SOD_W-1:0]       in_sod,
  input  logic signed [MV_W-1:0] in_x,
  input  logic signed [MV_W-1:0] in_y,
  output logic [SOD_W-1:0]       min_sod,
  output logic signed [MV_W-1:0] min_x,
  output logic signed [MV_W-1:0] min_y
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_sod <= '1;
      min_x   <= '0;
      min_y   <= '0;
    end else if (clr) begin
      min_sod <= '1;
      min_x   <= '0;
      min_y   <= '0;
    end else if (upd && (in_sod < min_sod)) begin
      min_sod <= in_sod;
      min_x   <= in_x;
      min_y   <= in_y;
    end
  end

  // R3: without a clear the stored minimum can only fall
  assert_min_never_rises_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> min_sod <= $past(min_sod));

  // R3: an equal or larger score leaves the stored entry untouched
  assert_tie_keeps_earlier_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && upd && in_sod >= min_sod) |=> ($stable(min_sod) && $stable(min_x) && $stable(min_y)));

endmodule

// File: rtl/cross_refine.sv
module cross_refine import cr_pkg::*; #(
  parameter int BLK    = 8,
  parameter int RANGE  = 4,
  parameter int MV_W   = 4,
  parameter int N_CAND = 5,
  parameter int WIN    = BLK + 2 * RANGE,
  parameter int SOD_W  = $clog2(BLK * BLK + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     bidir,
  input  logic [BLK*BLK-1:0]       cur_blk,
  input  logic [WIN*WIN-1:0]       win_fwd,
  input  logic [WIN*WIN-1:0]       win_bwd,
  input  logic [N_CAND*MV_W-1:0]   cand_x,
  input  logic [N_CAND*MV_W-1:0]   cand_y,
  output logic                     done,
  output logic signed [MV_W-1:0]   fwd_mv_x,
  output logic signed [MV_W-1:0]   fwd_mv_y,
  output logic [SOD_W-1:0]         fwd_sod,
  output logic signed [MV_W-1:0]   bwd_mv_x,
  output logic signed [MV_W-1:0]   bwd_mv_y,
  output logic [SOD_W-1:0]         bwd_sod
);

  localparam int N_LANE = 2;
  localparam int HALF_A = (N_CAND + 1) / 2;
  localparam int HALF_B = N_CAND - HALF_A;
  localparam int CNT_W  = $clog2(N_CAND + 1);
  localparam int LAT_W  = $clog2(N_CAND + 8);

  cr_state_e              state;
  logic [CNT_W-1:0]       cnt;
  logic                   mode_bi;
  logic signed [MV_W-1:0] cx_q [N_CAND];
  logic signed [MV_W-1:0] cy_q [N_CAND];
  logic                   start_acc;
  int                     eval_len;

  assign start_acc = (state == CR_IDLE) && start;
  assign eval_len  = mode_bi ? N_CAND : HALF_A;

  // Candidate capture, only when a run is accepted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CAND; i++) begin
        cx_q[i] <= '0;
        cy_q[i] <= '0;
      end
    end else if (start_acc) begin
      for (int i = 0; i < N_CAND; i++) begin
        cx_q[i] <= cand_x[i*MV_W +: MV_W];
        cy_q[i] <= cand_y[i*MV_W +: MV_W];
      end
    end
  end

  // Lanes: lane 0 always on the forward window; lane 1 on the backward
  // window in bidirectional mode, else on the forward window with the
  // upper group of candidates.
  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    int                     base;
    int                     limit;
    int                     cidx;
    logic                   ln_valid;
    logic [WIN*WIN-1:0]     ln_win;
    logic signed [MV_W-1:0] e_x;
    logic signed [MV_W-1:0] e_y;
    logic [SOD_W-1:0]       e_sod;
    logic                   s1_valid;
    logic signed [MV_W-1:0] s1_x;
    logic signed [MV_W-1:0] s1_y;
    logic [SOD_W-1:0]       s1_sod;
    logic signed [MV_W-1:0] t_x;
    logic signed [MV_W-1:0] t_y;
    logic [SOD_W-1:0]       t_sod;

    always_comb begin
      base     = (l == 1 && !mode_bi) ? HALF_A : 0;
      limit    = mode_bi ? N_CAND : ((l == 0) ? HALF_A : HALF_B);
      ln_valid = (state == CR_EVAL) && (int'(cnt) < limit);
      cidx     = ln_valid ? (int'(cnt) + base) : 0;
      ln_win   = (l == 1 && mode_bi) ? win_bwd : win_fwd;
    end

    cr_cross_engine #(
      .BLK(BLK), .RANGE(RANGE), .MV_W(MV_W), .SOD_W(SOD_W), .WIN(WIN)
    ) u_eng (
      .cur     (cur_blk),
      .win     (ln_win),
      .cen_x   (cx_q[cidx]),
      .cen_y   (cy_q[cidx]),
      .best_x  (e_x),
      .best_y  (e_y),
      .best_sod(e_sod)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_valid <= 1'b0;
        s1_x     <= '0;
        s1_y     <= '0;
        s1_sod   <= '0;
      end else begin
        s1_valid <= ln_valid;
        s1_x     <= e_x;
        s1_y     <= e_y;
        s1_sod   <= e_sod;
      end
    end

    cr_min_tracker #(.MV_W(MV_W), .SOD_W(SOD_W)) u_trk (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (state == CR_INIT),
      .upd    (s1_valid),
      .in_sod (s1_sod),
      .in_x   (s1_x),
      .in_y   (s1_y),
      .min_sod(t_sod),
      .min_x  (t_x),
      .min_y  (t_y)
    );

    // R7: every scored position lies inside the search range
    assert_lane_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |-> (s1_x >= -RANGE && s1_x <= RANGE && s1_y >= -RANGE && s1_y <= RANGE));

    // R2: a block SOD never exceeds the pixel count
    assert_sod_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |-> int'(s1_sod) <= BLK * BLK);
  end

  // Unidirectional merge: upper group wins only when strictly better.
  logic b_better;
  assign b_better = g_lane[1].t_sod < g_lane[0].t_sod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= CR_IDLE;
      cnt      <= '0;
      mode_bi  <= 1'b0;
      done     <= 1'b0;
      fwd_mv_x <= '0;
      fwd_mv_y <= '0;
      fwd_sod  <= '1;
      bwd_mv_x <= '0;
      bwd_mv_y <= '0;
      bwd_sod  <= '1;
    end else begin
      done <= 1'b0;
      case (state)
        CR_IDLE: begin
          if (start) begin
            state   <= CR_INIT;
            mode_bi <= bidir;
          end
        end
        CR_INIT: begin
          state <= CR_EVAL;
          cnt   <= '0;
        end
        CR_EVAL: begin
          if (int'(cnt) == eval_len - 1) state <= CR_DRAIN;
          else cnt <= cnt + 1'b1;
        end
        CR_DRAIN: state <= CR_FIN;
        CR_FIN: begin
          state <= CR_IDLE;
          done  <= 1'b1;
          if (mode_bi) begin
            fwd_mv_x <= g_lane[0].t_x;
            fwd_mv_y <= g_lane[0].t_y;
            fwd_sod  <= g_lane[0].t_sod;
            bwd_mv_x <= g_lane[1].t_x;
            bwd_mv_y <= g_lane[1].t_y;
            bwd_sod  <= g_lane[1].t_sod;
          end else begin
            fwd_mv_x <= b_better ? g_lane[1].t_x : g_lane[0].t_x;
            fwd_mv_y <= b_better ? g_lane[1].t_y : g_lane[0].t_y;
            fwd_sod  <= b_better ? g_lane[1].t_sod : g_lane[0].t_sod;
            bwd_mv_x <= '0;
            bwd_mv_y <= '0;
            bwd_sod  <= '1;
          end
        end
        default: state <= CR_IDLE;
      endcase
    end
  end

  // Cycle counter for the latency check only.
  logic [LAT_W-1:0] lat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_cnt <= '0;
    else if (start_acc) lat_cnt <= LAT_W'(1);
    else if (state != CR_IDLE) lat_cnt <= lat_cnt + 1'b1;
  end

  // R6: the counter reads edges-since-accept plus one in the done cycle
  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> int'(lat_cnt) == (mode_bi ? N_CAND : HALF_A) + 4);

  // R8: done lasts a single cycle
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a run in progress keeps its mode and candidates
  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != CR_IDLE) |=> ($stable(mode_bi) && $stable(cx_q[0]) && $stable(cy_q[N_CAND-1])));

  // R8: outputs only move together with done
  assert_outputs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || ($stable(fwd_sod) && $stable(bwd_sod) && $stable(fwd_mv_x) && $stable(bwd_mv_y))));

  // R5: unidirectional runs report an idle backward result
  assert_uni_bwd_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_bi) |-> (bwd_sod == '1 && bwd_mv_x == 0 && bwd_mv_y == 0));

  // R4: bidirectional runs deliver real scores on both sides
  assert_bidir_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_bi) |-> (int'(fwd_sod) <= BLK * BLK && int'(bwd_sod) <= BLK * BLK));

endmodule

// File: tb/sim_cross_refine.sv
module sim_cross_refine;

  localparam int BLK = 8, RANGE = 4, MV_W = 4, NC = 5;
  localparam int WIN = BLK + 2 * RANGE;
  localparam int WB = WIN * WIN;
  localparam int NB = BLK * BLK;

  typedef struct packed {
    int fx; int fy; int fs;
    int bx; int by; int bs;
    int lat;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, bidir = 1'b0;
  logic [NB-1:0] cur = '0;
  logic [WB-1:0] wf = '0, wb = '0;
  logic [NC*MV_W-1:0] cxv = '0, cyv = '0;
  logic done;
  logic signed [MV_W-1:0] fx, fy, bx, by;
  logic [6:0] fs, bs;

  int cx [NC];
  int cy [NC];
  int checks = 0, fails = 0;
  int cyc = 0, start_cyc = 0;
  logic prev_done = 1'b0;
  exp_t exp_q [$];

  always #10 clk = ~clk;  // 50 MHz

  cross_refine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .bidir(bidir), .cur_blk(cur),
    .win_fwd(wf), .win_bwd(wb), .cand_x(cxv), .cand_y(cyv), .done(done),
    .fwd_mv_x(fx), .fwd_mv_y(fy), .fwd_sod(fs),
    .bwd_mv_x(bx), .bwd_mv_y(by), .bwd_sod(bs)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int rclamp(input int v);
    return (v > RANGE) ? RANGE : ((v < -RANGE) ? -RANGE : v);
  endfunction

  function automatic int rsod(input logic [WB-1:0] w, input logic [NB-1:0] c, input int x, input int y);
    int n = 0;
    for (int r = 0; r < BLK; r++)
      for (int k = 0; k < BLK; k++)
        if (w[(RANGE+y+r)*WIN + RANGE + x + k] != c[r*BLK+k]) n++;
    return n;
  endfunction

  // Sequential reference: candidates in index order, points centre/up/down/right.
  task automatic ref_best(input logic [WB-1:0] w, output int rx, output int ry, output int rs);
    rs = 1000; rx = 0; ry = 0;
    for (int i = 0; i < NC; i++) begin
      for (int k = 0; k < 4; k++) begin
        int px, py, s;
        px = rclamp(cx[i] + ((k == 3) ? 1 : 0));
        py = rclamp(cy[i] + ((k == 1) ? -1 : ((k == 2) ? 1 : 0)));
        s = rsod(w, cur, px, py);
        if (s < rs) begin rs = s; rx = px; ry = py; end
      end
    end
  endtask

  // Driver: predict, push to scoreboard, pulse start, wait until consumed.
  task automatic run(input bit bi, input bit poke_busy);
    exp_t e;
    int a, b, c;
    for (int i = 0; i < NC; i++) begin
      cxv[i*MV_W +: MV_W] = MV_W'(cx[i]);
      cyv[i*MV_W +: MV_W] = MV_W'(cy[i]);
    end
    ref_best(wf, a, b, c);
    e.fx = a; e.fy = b; e.fs = c;
    if (bi) begin
      ref_best(wb, a, b, c);
      e.bx = a; e.by = b; e.bs = c;
    end else begin
      e.bx = 0; e.by = 0; e.bs = 127;
    end
    e.lat = bi ? 8 : 6;
    exp_q.push_back(e);
    @(negedge clk);
    bidir = bi; start = 1'b1; start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    if (poke_busy) begin
      repeat (2) @(negedge clk);
      bidir = ~bi; start = 1'b1;  // R8: must be ignored mid-run
      @(negedge clk);
      start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pop and compare on each done.
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) check(1'b0, "R8 done longer than one cycle", 1, 0);
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(int'(fx) == e.fx, "R4/R5 fwd x", int'(fx), e.fx);
          check(int'(fy) == e.fy, "R4/R5 fwd y", int'(fy), e.fy);
          check(int'(fs) == e.fs, "R2/R3 fwd sod", int'(fs), e.fs);
          check(int'(bx) == e.bx, "R4/R5 bwd x", int'(bx), e.bx);
          check(int'(by) == e.by, "R4/R5 bwd y", int'(by), e.by);
          check(int'(bs) == e.bs, "R4/R5 bwd sod", int'(bs), e.bs);
          check(cyc - start_cyc - 1 == e.lat, "R6 latency", cyc - start_cyc - 1, e.lat);
        end
      end
    end
    prev_done = done;
  end

  task automatic rand_all();
    for (int i = 0; i < WB / 32; i++) begin
      wf[i*32 +: 32] = $urandom();
      wb[i*32 +: 32] = $urandom();
    end
    cur = {$urandom(), $urandom()};
    for (int i = 0; i < NC; i++) begin
      cx[i] = int'($urandom_range(0, 8)) - 4;
      cy[i] = int'($urandom_range(0, 8)) - 4;
    end
  endtask

  task automatic plant(inout logic [WB-1:0] w, input int x, input int y);
    for (int r = 0; r < BLK; r++)
      for (int k = 0; k < BLK; k++)
        w[(RANGE+y+r)*WIN + RANGE + x + k] = cur[r*BLK+k];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(fs == 7'd127 && bs == 7'd127, "R1 sod", int'(fs), 127);
    check(fx == 0 && fy == 0 && bx == 0 && by == 0, "R1 vectors", int'(fx), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4, R9: bidirectional random runs
    for (int t = 0; t < 3; t++) begin rand_all(); run(1'b1, 1'b0); end
    // R5: unidirectional random runs
    for (int t = 0; t < 3; t++) begin rand_all(); run(1'b0, 1'b0); end

    // R2: exact match reached through the right-hand point
    rand_all();
    plant(wf, 2, -1);
    cx = '{1, -3, 0, -2, 4}; cy = '{-1, 3, 0, 2, -4};
    run(1'b0, 1'b0);
    check(fx == 2 && fy == -1 && fs == 0, "R2 right point match", int'(fs), 0);

    // R2: match only through the dropped left point stays unseen
    rand_all();
    plant(wb, 2, -1);
    cx = '{3, 3, 3, 3, 3}; cy = '{-1, -1, -1, -1, -1};
    run(1'b1, 1'b0);
    check(bs != 0, "R2 left point never scored", int'(bs), 1);

    // R3: all-equal scores keep candidate 0 centre
    wf = '0; wb = '0; cur = '0;
    cx = '{-1, 2, 0, 3, -3}; cy = '{2, -2, 1, 0, 3};
    run(1'b1, 1'b0);
    check(fx == -1 && fy == 2 && fs == 0, "R3 tie fwd keeps first", int'(fx), -1);
    check(bx == -1 && by == 2, "R3 tie bwd keeps first", int'(by), 2);
    cx = '{-1, 2, 0, 3, -3}; cy = '{2, -2, 1, 0, 3};
    run(1'b0, 1'b0);
    check(fx == -1 && fy == 2, "R3/R5 tie across lanes", int'(fx), -1);

    // R7: extreme candidates are clamped
    rand_all();
    cx = '{7, -8, 7, -8, 4}; cy = '{7, -8, -8, 7, 4};
    run(1'b1, 1'b0);
    check(fx >= -4 && fx <= 4 && fy >= -4 && fy <= 4, "R7 fwd clamped", int'(fx), 4);
    check(bx >= -4 && bx <= 4 && by >= -4 && by <= 4, "R7 bwd clamped", int'(bx), 4);

    // R8: start and mode change during a run are ignored
    rand_all();
    run(1'b1, 1'b1);
    rand_all();
    run(1'b0, 1'b1);
    check(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule